// File: doc/BRIEF.md
# Lockable SMBus Configuration Register Slave

This block is a two-wire serial slave that exposes a small bank of 8-bit configuration registers to a host. It handles the two single-byte transfers: a byte write and a byte read. Both carry a command byte. When the command's top bit is set, its low seven bits select the register.

Updates are gated by two bits held in register 0. Bit 0 is an unlock bit. While it is clear, only bit 0 itself can be changed. A new value of the unlock bit counts only from the transaction after the one that wrote it. Bit 7 is a write-once freeze: writing it to 1 from an unlocked transaction stops every further change until reset. Writes that are refused are still acknowledged on the bus. The register contents drive parallel outputs, such as clock-output enables. The bus wires are open-drain: each is seen as an input, and the slave pulls SDA low through an enable. Both wires are oversampled on the system clock.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The slave acknowledges only its own 7-bit address (default 0x69). For any other address it leaves SDA released for the rest of the transaction.
- R2: An unlocked byte write (start, address+W, command, data, stop) stores the data byte in the register selected by command bits [6:0].
- R3: A byte read (start, address+W, command, repeated start, address+R, data with MSB first, NACK, stop) returns the current value of the selected register. The read works whatever the lock state.
- R4: After reset, register 0 is 0x00, register 1 is 0xFE, and every other register is 0x00.
- R5: While the unlock bit (register 0 bit 0) is 0, a write changes nothing except register 0 bit 0.
- R6: The unlock bit is sampled at the start condition of each transaction. Writing 0xFF to register 0 while locked therefore yields 0x01.
- R7: Register 0 bit 7 written to 1 from an unlocked transaction freezes all registers, including bit 0, until reset. After reset the reset values return.
- R8: Every byte of an addressed write transaction is acknowledged, whether or not the write takes effect.
- R9: A command with bit 7 clear, or with an offset past the last register, is acknowledged. A write with such a command has no effect, and a read with it returns 0x00.
- R10: A stop condition ends the transaction at once and releases SDA. A write cut off before its data byte changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| scl_i | input | 1 | Sensed level of the SCL wire |
| sda_i | input | 1 | Sensed level of the SDA wire |
| sda_oe | output | 1 | When 1, the slave pulls SDA low |
| cfg_o | output | NUM_REGS*8 | All registers; register k sits at bits [8k+7:8k] |

## Verification
Two functions share a single clock edge: the commit of a data byte into register 0, and the lock gate that judges that same commit. The unlock bit being written is also the one that decides how much of the byte lands, and the freeze bit being set depends on the unlock value latched at start. The bench provokes this in two ways. It writes 0xFF to register 0 while locked, where only bit 0 may change. It writes 0x81 while unlocked, where the freeze takes hold and every later write must bounce. A behavioural model applies the lock rules per transaction, and the register outputs are compared with it on every idle clock.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_CMD, ST_ACK_C,
    ST_WDATA, ST_ACK_D, ST_RDATA, ST_ACK_R, ST_SKIP
  } smb_state_e;

  localparam int LOCK_REG = 0;
  localparam int WEN_BIT  = 0;
  localparam int WDIS_BIT = 7;

  function automatic logic [7:0] reg_reset_val(input int idx);
    return (idx == 1) ? 8'hFE : 8'h00;
  endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_q     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       txn_start,
  output logic       wr_stb,
  output logic [7:0] cmd_o,
  output logic [7:0] wr_data
);
  smb_state_e state;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      is_rd     <= 1'b0;
      sda_oe    <= 1'b0;
      txn_start <= 1'b0;
      wr_stb    <= 1'b0;
      cmd_o     <= '0;
      wr_data   <= '0;
    end else begin
      txn_start <= 1'b0;
      wr_stb    <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state     <= ST_ADDR;
        cnt       <= '0;
        sda_oe    <= 1'b0;
        txn_start <= 1'b1;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  is_rd  <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ACK_A;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_CMD) begin
                cmd_o  <= sh;
                sda_oe <= 1'b1;
                state  <= ST_ACK_C;
              end else begin
                wr_data <= sh;
                wr_stb  <= 1'b1;
                sda_oe  <= 1'b1;
                state   <= ST_ACK_D;
              end
            end
          end
          ST_ACK_A: if (scl_fall) begin
            if (is_rd) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              cnt    <= '0;
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_CMD;
            end
          end
          ST_ACK_C: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WDATA;
          end
          ST_ACK_D: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_SKIP;
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_ACK_R;
            end else if (scl_fall && cnt != 4'd0) begin
              sda_oe <= ~tx[6];
              tx     <= {tx[6:0], 1'b0};
            end
          end
          ST_ACK_R: if (scl_fall) state <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end

  // R1
  skip_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP || state == ST_IDLE) |=> (!sda_oe || start_det));

  // R8
  data_ack_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> sda_oe);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  txn_start,
  input  logic                  wr_stb,
  input  logic [7:0]            cmd,
  input  logic [7:0]            wr_data,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int         IDX_W = $clog2(NUM_REGS);
  localparam logic [6:0] NREG  = 7'(NUM_REGS);

  logic [7:0] regs_q [NUM_REGS];
  logic       wen_lat;
  logic       hit;
  logic       wdis;

  assign hit  = cmd[7] && (cmd[6:0] < NREG);
  assign wdis = regs_q[LOCK_REG][WDIS_BIT];

  always_ff @(posedge clk) begin
    if (rst)            wen_lat <= 1'b0;
    else if (txn_start) wen_lat <= regs_q[LOCK_REG][WEN_BIT];
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic sel;
    assign sel = wr_stb && hit && !wdis && (cmd[IDX_W-1:0] == IDX_W'(k));
    if (k == LOCK_REG) begin : g_lock
      always_ff @(posedge clk) begin
        if (rst) regs_q[k] <= reg_reset_val(k);
        else if (sel) begin
          if (wen_lat) regs_q[k] <= wr_data;
          else         regs_q[k][WEN_BIT] <= wr_data[WEN_BIT];
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                 regs_q[k] <= reg_reset_val(k);
        else if (sel && wen_lat) regs_q[k] <= wr_data;
      end
    end
    assign regs_o[k*8 +: 8] = regs_q[k];
  end

  assign rd_data = hit ? regs_q[cmd[IDX_W-1:0]] : 8'h00;

  // R7
  wdis_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    regs_o[WDIS_BIT] |=> regs_o[WDIS_BIT]);

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    regs_o[WDIS_BIT] |=> $stable(regs_o));

  // R5
  locked_chk: assert property (@(posedge clk) disable iff (rst)
    !wen_lat |=> $stable(regs_o[NUM_REGS*8-1:1]));

  // R6
  wen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !txn_start |=> $stable(wen_lat));
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       txn_start, wr_stb;
  logic [7:0] cmd, wr_data, rd_data;

  bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .txn_start(txn_start),
    .wr_stb(wr_stb), .cmd_o(cmd), .wr_data(wr_data)
  );

  cfg_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst(rst), .txn_start(txn_start), .wr_stb(wr_stb),
    .cmd(cmd), .wr_data(wr_data), .rd_data(rd_data), .regs_o(cfg_o)
  );
endmodule

// File: tb/tb_cfg_smbus_slave.sv
module tb_cfg_smbus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 12;
  localparam int NREG       = 4;
  localparam logic [6:0] ADDR = 7'h69;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_i;
  logic [NREG*8-1:0] cfg_o;

  assign sda_i = m_sda & ~sda_oe;

  cfg_smbus_slave #(.DEV_ADDR(ADDR), .NUM_REGS(NREG)) dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_i),
    .sda_oe(sda_oe), .cfg_o(cfg_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0;
  logic [7:0] m_reg [NREG];
  logic cmp_on = 1'b0;

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] f;
    for (int k = 0; k < NREG; k++) f[k*8 +: 8] = m_reg[k];
    return f;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NREG; k++) m_reg[k] = (k == 1) ? 8'hFE : 8'h00;
  endtask

  task automatic model_write(input logic [7:0] cmd, input logic [7:0] d);
    int off;
    bit unlocked;
    off = cmd[6:0];
    unlocked = m_reg[0][0];
    if (cmd[7] && off < NREG && !m_reg[0][7]) begin
      if (unlocked) m_reg[off] = d;
      else if (off == 0) m_reg[0][0] = d[0];
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-clock comparison of the outputs with the model (R2 R5 R6 R7)
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      vectors++;
      if (cfg_o !== model_flat()) begin
        fails++;
        $display("FAIL R2/R5: actual %h expected %h", cfg_o, model_flat());
      end
    end
  end

  task automatic wc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_out(input logic b);
    wc(H/2); m_sda = b; wc(H/2); m_scl = 1'b1; wc(H); m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wc(H/2); m_sda = 1'b1; wc(H/2); m_scl = 1'b1; wc(H/2); b = sda_i; wc(H/2); m_scl = 1'b0;
  endtask

  task automatic byte_out(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic byte_in(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(1'b1);
  endtask

  task automatic cond_start();
    m_sda = 1'b1; wc(H/2); m_scl = 1'b1; wc(H/2); m_sda = 1'b0; wc(H/2); m_scl = 1'b0;
  endtask

  task automatic cond_stop();
    wc(H/2); m_sda = 1'b0; wc(H/2); m_scl = 1'b1; wc(H/2); m_sda = 1'b1; wc(H);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] cmd,
                          input logic [7:0] d, input string req);
    logic a1, a2, a3;
    cmp_on = 1'b0;
    cond_start();
    byte_out({a, 1'b0}, a1);
    chk({req, " R1 addr ack"}, a1, a == ADDR);
    if (a1) begin
      byte_out(cmd, a2);
      byte_out(d, a3);
      chk({req, " R8 cmd ack"}, a2, 1);
      chk({req, " R8 data ack"}, a3, 1);
      model_write(cmd, d);
    end
    cond_stop();
    wc(4);
    cmp_on = 1'b1;
  endtask

  task automatic do_read(input logic [7:0] cmd, input logic [7:0] exp, input string req);
    logic a1, a2, a3;
    logic [7:0] d;
    cmp_on = 1'b0;
    cond_start();
    byte_out({ADDR, 1'b0}, a1);
    byte_out(cmd, a2);
    cond_start();
    byte_out({ADDR, 1'b1}, a3);
    byte_in(d);
    cond_stop();
    chk({req, " acks"}, {a1, a2, a3}, 3'b111);
    chk({req, " data"}, d, exp);
    wc(4);
    cmp_on = 1'b1;
  endtask

  task automatic do_reset();
    cmp_on = 1'b0;
    rst = 1'b1;
    wc(5);
    rst = 1'b0;
    model_reset();
    wc(2);
    cmp_on = 1'b1;
  endtask

  initial begin
    model_reset();
    wc(5);
    rst = 1'b0;
    wc(2);
    // R4: reset values
    chk("R4 reset", cfg_o, 32'h0000_FE00);
    chk("R1 idle release", sda_oe, 0);
    cmp_on = 1'b1;

    // R5/R8: locked write to register 1 is acked but ignored
    do_write(ADDR, 8'h81, 8'h55, "R5");
    chk("R5 reg1 kept", cfg_o[15:8], 8'hFE);

    // R6: 0xFF to register 0 while locked sets only bit 0
    do_write(ADDR, 8'h80, 8'hFF, "R6");
    chk("R6 reg0", cfg_o[7:0], 8'h01);

    // R2: unlocked write
    do_write(ADDR, 8'h81, 8'h55, "R2");
    chk("R2 reg1", cfg_o[15:8], 8'h55);
    do_write(ADDR, 8'h83, 8'hA5, "R2");
    chk("R2 reg3", cfg_o[31:24], 8'hA5);

    // R3: reads
    do_read(8'h81, 8'h55, "R3 reg1");
    do_read(8'h83, 8'hA5, "R3 reg3");

    // R1: foreign address not acknowledged, nothing changes
    do_write(7'h2C, 8'h82, 8'h77, "R1");
    chk("R1 reg2 kept", cfg_o[23:16], 8'h00);

    // R9: bad commands
    do_write(ADDR, 8'h02, 8'h99, "R9");
    do_write(ADDR, 8'h85, 8'h99, "R9");
    chk("R9 regs kept", cfg_o, 32'hA500_5501);
    do_read(8'h01, 8'h00, "R9 msb0 read");
    do_read(8'h85, 8'h00, "R9 range read");

    // R10: stop before the data byte aborts the write
    begin
      logic a1, a2;
      cmp_on = 1'b0;
      cond_start();
      byte_out({ADDR, 1'b0}, a1);
      byte_out(8'h82, a2);
      cond_stop();
      wc(4);
      cmp_on = 1'b1;
      chk("R10 sda released", sda_oe, 0);
      chk("R10 reg2 kept", cfg_o[23:16], 8'h00);
    end

    // R5: relock with 0x00, then a write to register 2 bounces
    do_write(ADDR, 8'h80, 8'h00, "R5");
    chk("R5 reg0 cleared", cfg_o[7:0], 8'h00);
    do_write(ADDR, 8'h82, 8'h33, "R5");
    chk("R5 reg2 locked", cfg_o[23:16], 8'h00);
    do_read(8'h81, 8'h55, "R3 locked read");

    // R7: unlock, then freeze
    do_write(ADDR, 8'h80, 8'h01, "R7");
    do_write(ADDR, 8'h80, 8'h81, "R7");
    chk("R7 reg0 frozen val", cfg_o[7:0], 8'h81);
    do_write(ADDR, 8'h81, 8'h00, "R7");
    do_write(ADDR, 8'h80, 8'h00, "R7");
    chk("R7 frozen", cfg_o, 32'hA500_5581);
    do_read(8'h81, 8'h55, "R3 frozen read");

    // R7/R4: reset clears the freeze
    do_reset();
    chk("R7 reset", cfg_o, 32'h0000_FE00);
    do_write(ADDR, 8'h80, 8'h01, "R7");
    do_write(ADDR, 8'h82, 8'h3C, "R7");
    chk("R7 writable again", cfg_o[23:16], 8'h3C);

    cmp_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule